// File: doc/BRIEF.md
# Flash Write-Engine Status Byte with Read Capture

This block keeps the eight-bit status byte that a flash memory's internal write engine exposes to the host. It tracks whether the engine is busy or idle. It also tracks whether an erase is suspended. Three failure flags record a failed erase, a failed program and a missing programming voltage. The failure flags are sticky: engine events set them, and only an explicit clear command removes them. Command decoding and the engine itself live elsewhere. The decoder and the engine deliver single-cycle pulses to this block.

On the bus side, a capture register takes a snapshot of the status byte when a read cycle begins. A read cycle begins when both the chip-enable and output-enable strobes (active low) are low, so the strobe that falls last starts the read. The snapshot stays frozen for the rest of the cycle. The host therefore never sees the byte change while it is reading. The strobes are brought into the clock domain through a parameterised synchroniser first. While the voltage failure flag is set, the block also raises a flag that tells the controller to refuse new program or erase operations.

Top module: `flash_stat_reg`

## Requirements
- R1: After reset the status byte is 80h (idle), the read output is 80h and the blocking flag is 0.
- R2: Status bit 7 (ready) goes to 0 on an operation-start pulse that arrives while the programming voltage is good. It goes back to 1 on an operation-done pulse.
- R3: A program-failure pulse sets bit 4 and an erase-failure pulse sets bit 5. Both bits stay set across later start and done pulses.
- R4: A clear-status pulse clears bits 5, 4 and 3 and leaves bits 7 and 6 unchanged.
- R5: An operation-start pulse while the programming voltage is low sets bit 3. It also sets bit 4 when the operation kind is 0 (program) or bit 5 when the kind is 1 (erase), and it leaves bit 7 unchanged.
- R6: The blocking output equals status bit 3 and clears only through the clear-status pulse.
- R7: An erase-suspended pulse sets bit 6 and bit 7. A resume pulse clears both of them.
- R8: Bits 2 to 0 of the read output are always 0.
- R9: The read output captures the status byte when the later of the two enable strobes goes low. It shows the new value no more than SYNC_STAGES+2 rising clock edges after that fall. A single low strobe captures nothing.
- R10: While both strobes stay low the read output does not change, even if the status byte does. A fresh capture needs one strobe to go high and then low again.
- R11: When a set and a clear for the same sticky bit arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start_i | input | 1 | Pulse: engine begins a program or erase |
| op_kind_i | input | 1 | Kind of the starting operation: 0 program, 1 erase |
| op_done_i | input | 1 | Pulse: engine finished the operation |
| prog_fail_i | input | 1 | Pulse: program verify failed |
| erase_fail_i | input | 1 | Pulse: erase verify failed |
| susp_ack_i | input | 1 | Pulse: erase reached its suspend point |
| resume_i | input | 1 | Pulse: suspended erase resumes |
| clr_cmd_i | input | 1 | Pulse: clear-status command decoded |
| vpp_ok_i | input | 1 | Programming voltage is at its high level |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_data_o | output | 8 | Captured status byte for the data bus |
| vpp_block_o | output | 1 | Voltage failure pending, refuse new operations |

## Verification
A wrong flag bit only appears at the ports at the next read capture, which is SYNC_STAGES+2 edges after the strobes fall. For that reason each event is followed by a full read cycle before the next event. A sticky bit that leaks away, or a clear that hits bits 7 or 6, shows up as a wrong byte on the read right after that event. A capture that triggers on the wrong strobe edge, or that keeps tracking the register during a read, shows up as a byte that changes while both strobes are held low. It also shows up as a byte that arrives while only one strobe is low.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
   localparam int unsigned STAT_W    = 8;
   localparam int unsigned BIT_READY = 7;
   localparam int unsigned BIT_SUSP  = 6;
   localparam int unsigned BIT_EFAIL = 5;
   localparam int unsigned BIT_PFAIL = 4;
   localparam int unsigned BIT_VPP   = 3;
   localparam int unsigned RSV_W     = 3;

   localparam logic [STAT_W-1:0] STAT_RESET = STAT_W'(1) << BIT_READY;

   typedef enum logic {
      OPK_PROG  = 1'b0,
      OPK_ERASE = 1'b1
   } op_kind_e;

   typedef struct packed {
      logic     start_ok;
      logic     start_bad;
      op_kind_e kind;
      logic     done;
      logic     pfail;
      logic     efail;
      logic     susp;
      logic     resume;
      logic     clr;
   } stat_evt_t;
endpackage

// File: rtl/fsr_strobe_sync.sv
module fsr_strobe_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH == 0) begin : g_bad_width
      $error("fsr_strobe_sync: WIDTH must be at least 1");
   end
   if (STAGES > 4) begin : g_bad_stages
      $error("fsr_strobe_sync: STAGES must not exceed 4");
   end

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q[s] <= {WIDTH{RST_VAL}};
            end else if (s == 0) begin
               stg_q[s] <= d_i;
            end else begin
               stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
            end
         end
      end
      assign q_o = stg_q[STAGES-1];
   end
endmodule

// File: rtl/fsr_flag_core.sv
module fsr_flag_core
   import flash_stat_pkg::*;
#(
   parameter int unsigned W = STAT_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  stat_evt_t    evt_i,
   output logic [W-1:0] stat_o
);
   if (W != STAT_W) begin : g_bad_w
      $error("fsr_flag_core: W must equal the package status width");
   end

   logic [W-1:0] stat_q;
   logic [W-1:0] stat_d;
   logic         set_p;
   logic         set_e;

   assign set_p = evt_i.pfail | (evt_i.start_bad & (evt_i.kind == OPK_PROG));
   assign set_e = evt_i.efail | (evt_i.start_bad & (evt_i.kind == OPK_ERASE));

   always_comb begin
      stat_d = stat_q;
      // ready: start or resume takes it low, done or suspend brings it high
      if (evt_i.start_ok | evt_i.resume) begin
         stat_d[BIT_READY] = 1'b0;
      end else if (evt_i.done | evt_i.susp) begin
         stat_d[BIT_READY] = 1'b1;
      end
      if (evt_i.resume) begin
         stat_d[BIT_SUSP] = 1'b0;
      end else if (evt_i.susp) begin
         stat_d[BIT_SUSP] = 1'b1;
      end
      // sticky flags: a set in the same cycle as a clear wins
      if (set_e) begin
         stat_d[BIT_EFAIL] = 1'b1;
      end else if (evt_i.clr) begin
         stat_d[BIT_EFAIL] = 1'b0;
      end
      if (set_p) begin
         stat_d[BIT_PFAIL] = 1'b1;
      end else if (evt_i.clr) begin
         stat_d[BIT_PFAIL] = 1'b0;
      end
      if (evt_i.start_bad) begin
         stat_d[BIT_VPP] = 1'b1;
      end else if (evt_i.clr) begin
         stat_d[BIT_VPP] = 1'b0;
      end
      stat_d[RSV_W-1:0] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= STAT_RESET;
      end else begin
         stat_q <= stat_d;
      end
   end

   assign stat_o = stat_q;
endmodule

// File: rtl/fsr_read_latch.sv
module fsr_read_latch #(
   parameter int unsigned         W       = 8,
   parameter logic        [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_now_i,
   input  logic [W-1:0] stat_i,
   output logic         en_prev_o,
   output logic [W-1:0] data_o
);
   logic         en_prev_q;
   logic [W-1:0] data_q;
   logic         capture;

   assign capture = en_now_i & ~en_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_prev_q <= 1'b0;
         data_q    <= RST_VAL;
      end else begin
         en_prev_q <= en_now_i;
         if (capture) begin
            data_q <= stat_i;
         end
      end
   end

   assign en_prev_o = en_prev_q;
   assign data_o    = data_q;
endmodule

// File: rtl/flash_stat_reg.sv
module flash_stat_reg
   import flash_stat_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_start_i,
   input  logic              op_kind_i,
   input  logic              op_done_i,
   input  logic              prog_fail_i,
   input  logic              erase_fail_i,
   input  logic              susp_ack_i,
   input  logic              resume_i,
   input  logic              clr_cmd_i,
   input  logic              vpp_ok_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   output logic [STAT_W-1:0] rd_data_o,
   output logic              vpp_block_o
);
   localparam int unsigned STROBES = 2;

   stat_evt_t           evt;
   logic [STAT_W-1:0]   stat_q;
   logic [STROBES-1:0]  strobe_n_s;
   logic                en_now;
   logic                en_prev;

   always_comb begin
      evt.start_ok  = op_start_i & vpp_ok_i;
      evt.start_bad = op_start_i & ~vpp_ok_i;
      evt.kind      = op_kind_e'(op_kind_i);
      evt.done      = op_done_i;
      evt.pfail     = prog_fail_i;
      evt.efail     = erase_fail_i;
      evt.susp      = susp_ack_i;
      evt.resume    = resume_i;
      evt.clr       = clr_cmd_i;
   end

   fsr_flag_core #(.W(STAT_W)) core_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt),
      .stat_o (stat_q)
   );

   fsr_strobe_sync #(
      .WIDTH   (STROBES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ce_n_i, oe_n_i}),
      .q_o   (strobe_n_s)
   );

   assign en_now = ~|strobe_n_s;

   fsr_read_latch #(
      .W       (STAT_W),
      .RST_VAL (STAT_RESET)
   ) latch_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_now_i  (en_now),
      .stat_i    (stat_q),
      .en_prev_o (en_prev),
      .data_o    (rd_data_o)
   );

   assign vpp_block_o = stat_q[BIT_VPP];
endmodule

// File: rtl/flash_stat_reg_chk.sv
module flash_stat_reg_chk
   import flash_stat_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              op_start_i,
   input logic              op_kind_i,
   input logic              op_done_i,
   input logic              prog_fail_i,
   input logic              susp_ack_i,
   input logic              resume_i,
   input logic              clr_cmd_i,
   input logic              vpp_ok_i,
   input logic [STAT_W-1:0] stat_q,
   input logic              en_now,
   input logic              en_prev,
   input logic [STAT_W-1:0] rd_data_o,
   input logic              vpp_block_o
);
   assert_ready_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start_i && vpp_ok_i) |=> !stat_q[BIT_READY]);

   assert_pfail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[BIT_PFAIL] && !clr_cmd_i) |=> stat_q[BIT_PFAIL]);

   assert_clear_pfail_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd_i && !prog_fail_i && !op_start_i) |=> !stat_q[BIT_PFAIL]);

   assert_bad_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_start_i && !vpp_ok_i && !op_kind_i) |=> (stat_q[BIT_VPP] && stat_q[BIT_PFAIL]));

   assert_block_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vpp_block_o) |-> ($past(op_start_i) && !$past(vpp_ok_i)));

   assert_block_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vpp_block_o) |-> $past(clr_cmd_i));

   assert_suspend_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_ack_i && !resume_i && !op_start_i) |=> (stat_q[BIT_SUSP] && stat_q[BIT_READY]));

   assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[RSV_W-1:0] == '0);

   assert_hold_in_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en_prev && en_now) |=> $stable(rd_data_o));

   assert_no_capture_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en_now |=> $stable(rd_data_o));
endmodule

bind flash_stat_reg flash_stat_reg_chk chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_start_i  (op_start_i),
   .op_kind_i   (op_kind_i),
   .op_done_i   (op_done_i),
   .prog_fail_i (prog_fail_i),
   .susp_ack_i  (susp_ack_i),
   .resume_i    (resume_i),
   .clr_cmd_i   (clr_cmd_i),
   .vpp_ok_i    (vpp_ok_i),
   .stat_q      (stat_q),
   .en_now      (en_now),
   .en_prev     (en_prev),
   .rd_data_o   (rd_data_o),
   .vpp_block_o (vpp_block_o)
);

// File: tb/flash_stat_reg_tb_top.sv
module flash_stat_reg_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 6;
   localparam int RELEASE    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start_i = 1'b0, op_kind_i = 1'b0, op_done_i = 1'b0;
   logic       prog_fail_i = 1'b0, erase_fail_i = 1'b0;
   logic       susp_ack_i = 1'b0, resume_i = 1'b0, clr_cmd_i = 1'b0;
   logic       vpp_ok_i = 1'b1, ce_n_i = 1'b1, oe_n_i = 1'b1;
   logic [7:0] rd_data_o;
   logic       vpp_block_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t exp_q[$];
   event rd_ev;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_stat_reg dut_i (
      .clk(clk), .rst_n(rst_n),
      .op_start_i(op_start_i), .op_kind_i(op_kind_i), .op_done_i(op_done_i),
      .prog_fail_i(prog_fail_i), .erase_fail_i(erase_fail_i),
      .susp_ack_i(susp_ack_i), .resume_i(resume_i), .clr_cmd_i(clr_cmd_i),
      .vpp_ok_i(vpp_ok_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
      .rd_data_o(rd_data_o), .vpp_block_o(vpp_block_o)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // monitor: pops the expected byte and compares it with the bus output
   initial begin
      forever begin
         @(rd_ev);
         #1;
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rd_data_o, e.val, e.tag);
            chk({5'd0, rd_data_o[2:0]}, 8'h00, "R8 reserved bits");
         end
      end
   endtask_dummy: begin end
   end

   task automatic expect_bus(input logic [7:0] v, input string tag);
      exp_t e;
      e.val = v;
      e.tag = tag;
      exp_q.push_back(e);
      -> rd_ev;
      #2;
   endtask

   task automatic read_cycle(input logic [7:0] v, input string tag);
      ce_n_i = 1'b0;
      oe_n_i = 1'b0;
      repeat (SETTLE) @(negedge clk);
      expect_bus(v, tag);
      ce_n_i = 1'b1;
      oe_n_i = 1'b1;
      repeat (RELEASE) @(negedge clk);
   endtask

   // event pulse: 0 start,1 done,2 pfail,3 efail,4 susp,5 resume,6 clr
   task automatic pulse(input int which);
      case (which)
         0: op_start_i   = 1'b1;
         1: op_done_i    = 1'b1;
         2: prog_fail_i  = 1'b1;
         3: erase_fail_i = 1'b1;
         4: susp_ack_i   = 1'b1;
         5: resume_i     = 1'b1;
         default: clr_cmd_i = 1'b1;
      endcase
      @(negedge clk);
      {op_start_i, op_done_i, prog_fail_i, erase_fail_i, susp_ack_i, resume_i, clr_cmd_i} = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data_o, 8'h80, "R1 reset read output");
      chk({7'd0, vpp_block_o}, 8'h00, "R1 reset blocking flag");
      read_cycle(8'h80, "R1 reset status byte");

      op_kind_i = 1'b0;
      pulse(0);
      read_cycle(8'h00, "R2 busy after start");
      pulse(1);
      read_cycle(8'h80, "R2 ready after done");

      pulse(2);
      read_cycle(8'h90, "R3 program failure set");
      pulse(3);
      read_cycle(8'hB0, "R3 erase failure set");
      pulse(0);
      pulse(1);
      read_cycle(8'hB0, "R3 flags sticky over start and done");

      pulse(6);
      read_cycle(8'h80, "R4 clear status");

      vpp_ok_i  = 1'b0;
      op_kind_i = 1'b1;
      pulse(0);
      vpp_ok_i  = 1'b1;
      chk({7'd0, vpp_block_o}, 8'h01, "R6 blocking flag raised");
      read_cycle(8'hA8, "R5 low voltage erase start");
      op_kind_i = 1'b0;
      pulse(0);
      pulse(1);
      chk({7'd0, vpp_block_o}, 8'h01, "R6 blocking flag held");

      clr_cmd_i   = 1'b1;
      prog_fail_i = 1'b1;
      @(negedge clk);
      {clr_cmd_i, prog_fail_i} = '0;
      @(negedge clk);
      chk({7'd0, vpp_block_o}, 8'h00, "R6 blocking flag cleared");
      read_cycle(8'h90, "R11 set wins over clear");
      pulse(6);

      vpp_ok_i  = 1'b0;
      op_kind_i = 1'b0;
      pulse(0);
      vpp_ok_i  = 1'b1;
      read_cycle(8'h98, "R5 low voltage program start");
      pulse(6);

      op_kind_i = 1'b1;
      pulse(0);
      read_cycle(8'h00, "R2 erase busy");
      pulse(4);
      read_cycle(8'hC0, "R7 suspended");
      pulse(2);
      pulse(6);
      read_cycle(8'hC0, "R4 clear keeps ready and suspend");
      pulse(5);
      read_cycle(8'h00, "R7 resumed");
      pulse(1);
      read_cycle(8'h80, "R2 erase done");

      // late strobe: OE first, capture must wait for CE
      oe_n_i = 1'b0;
      repeat (SETTLE) @(negedge clk);
      pulse(2);
      expect_bus(8'h80, "R9 single strobe low captures nothing");
      ce_n_i = 1'b0;
      repeat (SETTLE) @(negedge clk);
      expect_bus(8'h90, "R9 capture on later strobe fall");
      pulse(3);
      repeat (SETTLE) @(negedge clk);
      expect_bus(8'h90, "R10 held during read");
      oe_n_i = 1'b1;
      repeat (RELEASE) @(negedge clk);
      expect_bus(8'h90, "R10 held after strobe rise");
      oe_n_i = 1'b0;
      repeat (SETTLE) @(negedge clk);
      expect_bus(8'hB0, "R10 new capture after retoggle");
      ce_n_i = 1'b1;
      oe_n_i = 1'b1;
      repeat (RELEASE) @(negedge clk);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule